// File: doc/BRIEF.md
# Atomic Link/Conditional-Store Reservation Monitor

This block sits in front of a small shared word memory and serves up to four cores. Alongside plain loads and stores, it offers the two halves of an atomic read-modify-write pair. The first half is a linked load: it returns the word and records a per-core reservation on that word address. The second half is a conditional store: it writes only while that reservation is still intact, and it reports whether it wrote. Software builds spin locks and atomic counters on this pair. If another core writes the linked word between the two halves, the conditional store fails, and the software retries.

Each core has one request slot: a valid bit, an operation code, a word address and write data. In every cycle a fixed-priority arbiter picks one valid request, lowest core index first. It raises that core's grant, and the request executes in the same cycle. A core keeps its request asserted until it sees its grant. One cycle later a single response bus reports the served core, the read data, and the outcome of a conditional store.

Top module: `llsc_monitor`

## Requirements
- R1: When several cores request in the same cycle, only the lowest-indexed valid core is granted. `req_grant` is a one-hot combinational vector, and exactly one request is served per cycle.
- R2: A request granted in cycle k produces `rsp_valid`=1 in cycle k+1, with `rsp_core` set to the served core index. `rsp_valid` is 0 in any cycle that follows a cycle with no grant.
- R3: Operation codes are 0 = load, 1 = store, 2 = linked load and 3 = conditional store. A load returns the addressed word on `rsp_rdata`. A store writes `wdata` to the addressed word, and `rsp_rdata` is 0.
- R4: A linked load returns the addressed word and records a valid reservation for the issuing core on that word address.
- R5: A conditional store whose issuing core holds a valid reservation on the same address writes memory. It returns `rsp_sc_ok`=1 and `rsp_rdata`=1.
- R6: A conditional store issued without a valid reservation, or to a different address than the one reserved, returns `rsp_sc_ok`=0 and `rsp_rdata`=0, and leaves memory unchanged.
- R7: A write to a word clears every other core's reservation on that word. A write here means a plain store or a successful conditional store. Writes to other addresses leave those reservations intact.
- R8: Every conditional store, whether it succeeds or fails, clears the issuing core's own reservation.
- R9: A new linked load replaces the core's earlier reservation address.
- R10: A plain store by a core does not clear that same core's own reservation.
- R11: After reset all memory words read 0, no core holds a reservation and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core request present |
| req_op | input | 2*NUM_CORES | Per-core operation code, core i in bits [2i+1:2i] |
| req_addr | input | ADDR_W*NUM_CORES | Per-core word address |
| req_wdata | input | DATA_W*NUM_CORES | Per-core write data |
| req_grant | output | NUM_CORES | One-hot grant, the request executes in this cycle |
| rsp_valid | output | 1 | Response present for the request granted last cycle |
| rsp_core | output | $clog2(NUM_CORES) | Index of the served core |
| rsp_rdata | output | DATA_W | Load data, or the conditional-store result as 0/1 |
| rsp_sc_ok | output | 1 | Conditional store succeeded |

## Verification
The pair is tried in several patterns, each isolating one way a link can be broken or kept. An uninterrupted linked load and conditional store must succeed. A foreign store to the same word must break the link, while a foreign store to a different word must not. A second linked load must move the reservation to the new address. The core's own plain store must leave its link intact. A two-core race, with both conditional stores presented in one cycle, shows that the lower-indexed core wins and that its write fails the other core's link. A four-way burst of requests shows the arbitration order.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;

    localparam int unsigned CORES_DEF  = 4;
    localparam int unsigned ADDR_W_DEF = 4;
    localparam int unsigned DATA_W_DEF = 32;

    // Operation codes carried on req_op
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } mem_op_e;

    // True when the operation updates memory
    function automatic logic op_writes(input mem_op_e op, input logic cond_ok);
        return (op == OP_STORE) || ((op == OP_COND) && cond_ok);
    endfunction

    // True when the operation returns the memory word
    function automatic logic op_reads(input mem_op_e op);
        return (op == OP_LOAD) || (op == OP_LINK);
    endfunction

endpackage

// File: rtl/llsc_prio_arb.sv
`timescale 1ns/1ps
module llsc_prio_arb #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so the lowest valid index is the last one written
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (valid[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/llsc_resv_bank.sv
`timescale 1ns/1ps
module llsc_resv_bank
    import llsc_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [IW-1:0] core,
    input  mem_op_e       op,
    input  logic [AW-1:0] addr,
    output logic          cond_ok,
    output logic [N-1:0]  link_valid
);
    logic          slot_v [N];
    logic [AW-1:0] slot_a [N];
    logic          do_write;

    // The issuing core's link must be live and on this exact word
    assign cond_ok  = slot_v[core] && (slot_a[core] == addr);
    assign do_write = fire && op_writes(op, cond_ok);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_v[g] <= 1'b0;
                slot_a[g] <= '0;
            end else if (fire) begin
                if (core == IW'(g)) begin
                    if (op == OP_LINK) begin
                        slot_v[g] <= 1'b1;
                        slot_a[g] <= addr;
                    end else if (op == OP_COND) begin
                        slot_v[g] <= 1'b0;
                    end
                end else if (do_write && (slot_a[g] == addr)) begin
                    // Another core changed the linked word
                    slot_v[g] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < int'(N); i++) link_valid[i] = slot_v[i];
    end
endmodule

// File: rtl/llsc_word_mem.sv
`timescale 1ns/1ps
module llsc_word_mem #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    // Asynchronous read, sampled into the response register by the top
    assign rdata = words[addr];
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int unsigned NUM_CORES = CORES_DEF,
    parameter int unsigned ADDR_W    = ADDR_W_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    localparam int unsigned CID_W    = $clog2(NUM_CORES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [2*NUM_CORES-1:0]        req_op,
    input  logic [ADDR_W*NUM_CORES-1:0]   req_addr,
    input  logic [DATA_W*NUM_CORES-1:0]   req_wdata,
    output logic [NUM_CORES-1:0]          req_grant,
    output logic                          rsp_valid,
    output logic [CID_W-1:0]              rsp_core,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic                          rsp_sc_ok
);
    typedef struct packed {
        mem_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } sel_req_t;

    logic [CID_W-1:0]  grant_idx;
    logic              fire;
    sel_req_t          sel;
    mem_op_e           sel_op;
    logic              cond_ok;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic [NUM_CORES-1:0] link_valid;

    llsc_prio_arb #(.N(NUM_CORES), .IW(CID_W)) u_arb (
        .valid (req_valid),
        .grant (req_grant),
        .idx   (grant_idx),
        .any   (fire)
    );

    // Route the granted core's request fields
    always_comb begin
        sel = '{op: OP_LOAD, addr: '0, wdata: '0};
        for (int i = 0; i < int'(NUM_CORES); i++) begin
            if (req_grant[i]) begin
                sel.op    = mem_op_e'(req_op[i*2 +: 2]);
                sel.addr  = req_addr[i*ADDR_W +: ADDR_W];
                sel.wdata = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end
    assign sel_op = sel.op;

    llsc_resv_bank #(.N(NUM_CORES), .AW(ADDR_W), .IW(CID_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .core       (grant_idx),
        .op         (sel.op),
        .addr       (sel.addr),
        .cond_ok    (cond_ok),
        .link_valid (link_valid)
    );

    assign mem_we = fire && op_writes(sel.op, cond_ok);

    llsc_word_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (sel.addr),
        .wdata (sel.wdata),
        .rdata (mem_rdata)
    );

    // Response register: one cycle after the grant
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_core  <= '0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= fire;
            rsp_core  <= grant_idx;
            rsp_sc_ok <= fire && (sel.op == OP_COND) && cond_ok;
            if (op_reads(sel.op))
                rsp_rdata <= mem_rdata;
            else if (sel.op == OP_COND)
                rsp_rdata <= DATA_W'(cond_ok);
            else
                rsp_rdata <= '0;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  req_valid,
    input logic [N-1:0]  req_grant,
    input logic [IW-1:0] grant_idx,
    input logic          fire,
    input mem_op_e       sel_op,
    input logic          cond_ok,
    input logic          mem_we,
    input logic [N-1:0]  link_valid,
    input logic          rsp_valid
);
    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant));

    p_grant_lowest_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid != '0) |-> (req_grant == (req_valid & (~req_valid + N'(1)))));

    p_rsp_after_grant_r2: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !rsp_valid);

    p_fail_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_op == OP_COND && !cond_ok) |-> !mem_we);

    p_link_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_op == OP_LINK) |=> link_valid[$past(grant_idx)]);

    p_cond_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_op == OP_COND) |=> !link_valid[$past(grant_idx)]);
endmodule

bind llsc_monitor llsc_monitor_chk #(.N(NUM_CORES), .IW(CID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_grant  (req_grant),
    .grant_idx  (grant_idx),
    .fire       (fire),
    .sel_op     (sel_op),
    .cond_ok    (cond_ok),
    .mem_we     (mem_we),
    .link_valid (link_valid),
    .rsp_valid  (rsp_valid)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int CW = 2;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC-1:0]     req_valid = '0;
    logic [2*NC-1:0]   req_op    = '0;
    logic [AW*NC-1:0]  req_addr  = '0;
    logic [DW*NC-1:0]  req_wdata = '0;
    logic [NC-1:0]     req_grant;
    logic              rsp_valid;
    logic [CW-1:0]     rsp_core;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_sc_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_rdata(rsp_rdata),
        .rsp_sc_ok(rsp_sc_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input int c, input logic [1:0] op,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_op[c*2 +: 2]     = op;
        req_addr[c*AW +: AW] = a;
        req_wdata[c*DW +: DW] = d;
        req_valid[c]         = 1'b1;
    endtask

    // Single request: granted at once, response sampled at the next negedge
    task automatic do_op(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd, output logic ok);
        @(negedge clk);
        set_req(c, op, a, d);
        @(posedge clk);
        #1 req_valid[c] = 1'b0;
        @(negedge clk);
        chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R2 rsp_core", 32'(rsp_core), 32'(c));
        rd = rsp_rdata;
        ok = rsp_sc_ok;
    endtask

    task automatic t_reset();
        logic [DW-1:0] rd; logic ok;
        chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        do_op(0, LD, 4'd5, '0, rd, ok);
        chk("R11 memory cleared", rd, 32'd0);
        do_op(2, SC, 4'd5, 32'h1234, rd, ok);
        chk("R11 no reservation", 32'(ok), 32'd0);
    endtask

    task automatic t_plain();
        logic [DW-1:0] rd; logic ok;
        do_op(2, ST, 4'd5, 32'hA5A5_0001, rd, ok);
        chk("R3 store rdata", rd, 32'd0);
        do_op(0, LD, 4'd5, '0, rd, ok);
        chk("R3 load after store", rd, 32'hA5A5_0001);
    endtask

    task automatic t_link_ok();
        logic [DW-1:0] rd; logic ok;
        do_op(1, ST, 4'd3, 32'h42, rd, ok);
        do_op(1, LL, 4'd3, '0, rd, ok);
        chk("R4 linked load data", rd, 32'h42);
        do_op(1, SC, 4'd3, 32'h77, rd, ok);
        chk("R5 cond ok", 32'(ok), 32'd1);
        chk("R5 cond rdata", rd, 32'd1);
        do_op(3, LD, 4'd3, '0, rd, ok);
        chk("R5 cond wrote", rd, 32'h77);
    endtask

    task automatic t_fail_paths();
        logic [DW-1:0] rd; logic ok;
        do_op(1, SC, 4'd3, 32'h99, rd, ok);
        chk("R8 second cond fails", 32'(ok), 32'd0);
        chk("R6 fail rdata", rd, 32'd0);
        do_op(1, LD, 4'd3, '0, rd, ok);
        chk("R6 memory kept", rd, 32'h77);
        do_op(0, LL, 4'd4, '0, rd, ok);
        do_op(0, SC, 4'd6, 32'h55, rd, ok);
        chk("R6 wrong address fails", 32'(ok), 32'd0);
        do_op(0, LD, 4'd6, '0, rd, ok);
        chk("R6 wrong address no write", rd, 32'd0);
        do_op(0, SC, 4'd4, 32'h56, rd, ok);
        chk("R8 failed cond cleared link", 32'(ok), 32'd0);
    endtask

    task automatic t_foreign_store();
        logic [DW-1:0] rd; logic ok;
        do_op(0, LL, 4'd7, '0, rd, ok);
        do_op(3, ST, 4'd7, 32'd0, rd, ok);
        do_op(0, SC, 4'd7, 32'h1, rd, ok);
        chk("R7 foreign store breaks link", 32'(ok), 32'd0);
        do_op(0, LL, 4'd8, '0, rd, ok);
        do_op(3, ST, 4'd9, 32'hBB, rd, ok);
        do_op(0, SC, 4'd8, 32'h11, rd, ok);
        chk("R7 other address keeps link", 32'(ok), 32'd1);
    endtask

    task automatic t_relink();
        logic [DW-1:0] rd; logic ok;
        do_op(2, LL, 4'd10, '0, rd, ok);
        do_op(2, LL, 4'd11, '0, rd, ok);
        do_op(2, SC, 4'd10, 32'hC0, rd, ok);
        chk("R9 old address dropped", 32'(ok), 32'd0);
        do_op(2, LL, 4'd10, '0, rd, ok);
        do_op(2, LL, 4'd11, '0, rd, ok);
        do_op(2, SC, 4'd11, 32'hC1, rd, ok);
        chk("R9 new address held", 32'(ok), 32'd1);
    endtask

    task automatic t_own_store();
        logic [DW-1:0] rd; logic ok;
        do_op(1, LL, 4'd12, '0, rd, ok);
        do_op(1, ST, 4'd12, 32'h5, rd, ok);
        do_op(1, SC, 4'd12, 32'h6, rd, ok);
        chk("R10 own store keeps link", 32'(ok), 32'd1);
        do_op(2, LD, 4'd12, '0, rd, ok);
        chk("R10 final value", rd, 32'h6);
    endtask

    task automatic t_race();
        logic [DW-1:0] rd; logic ok;
        do_op(0, LL, 4'd13, '0, rd, ok);
        do_op(1, LL, 4'd13, '0, rd, ok);
        @(negedge clk);
        set_req(0, SC, 4'd13, 32'h111);
        set_req(1, SC, 4'd13, 32'h222);
        #1 chk("R1 race grant", 32'(req_grant), 32'h1);
        @(posedge clk);
        #1 req_valid[0] = 1'b0;
        @(negedge clk);
        chk("R1 race first core", 32'(rsp_core), 32'd0);
        chk("R5 race winner", 32'(rsp_sc_ok), 32'd1);
        chk("R1 race second grant", 32'(req_grant), 32'h2);
        @(posedge clk);
        #1 req_valid[1] = 1'b0;
        @(negedge clk);
        chk("R1 race second core", 32'(rsp_core), 32'd1);
        chk("R7 race loser", 32'(rsp_sc_ok), 32'd0);
        do_op(3, LD, 4'd13, '0, rd, ok);
        chk("R7 race memory", rd, 32'h111);
    endtask

    task automatic t_burst();
        @(negedge clk);
        for (int c = 0; c < NC; c++) set_req(c, LD, AW'(c), '0);
        for (int k = 0; k < NC; k++) begin
            #1 chk("R1 burst grant", 32'(req_grant), 32'(1 << k));
            @(posedge clk);
            #1 req_valid[k] = 1'b0;
            @(negedge clk);
            chk("R2 burst rsp_core", 32'(rsp_core), 32'(k));
        end
        @(negedge clk);
        chk("R2 idle after burst", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_link_ok();
        t_fail_paths();
        t_foreign_store();
        t_relink();
        t_own_store();
        t_race();
        t_burst();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule